// File: doc/BRIEF.md
# Event Counter Bank for an I/O Translation Unit

This block is a bank of programmable event counters that watches an I/O address translation unit. The monitored unit supplies one strobe per event type on every clock. A stream filter outside this block tells each counter whether the current traffic belongs to it. Software programs and reads the bank through a simple 32-bit register port. A write takes effect at the clock edge where it is sampled. A read returns its data one cycle later.

Each counter has an event selector, a stream pattern with a span flag, a count enable, an interrupt enable and an overflow flag. The span flag and the pattern are driven out to the filter. Each of the three per-counter flag sets has a set alias and a clear alias. A counter that wraps from all ones to zero sets its overflow flag. Any overflowed counter whose interrupt enable is set drives a level interrupt, provided the global interrupt enable is on. Read-only words report the geometry of the bank and the event codes it supports.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, all counters, flag sets and global enables are zero, `irq` is low, `reg_rdata` is zero, and the configuration word at 0xE00 reads 0x00002F07 with the default parameters. That word holds counters-1 in bits 5:0, width-1 in bits 13:8 and the shared-filter flag in bit 23.
- R2: A counter wider than 32 bits occupies two words. Counter n has its low word at byte 8n and its high word at 8n+4. A counter of 32 bits or fewer takes one word at 4n. Bits above the counter width read as zero, and writes to them are dropped.
- R3: A counter adds one at each clock edge where all four of these hold: its selected strobe is high, its enable bit is set, the global count enable (bit 0 at 0xE04) is set, and its filter match input is high. If any one of them is low, the counter holds its value.
- R4: The event code sits in bits 15:0 and the span flag in bit 29 of the selector word at 0x400+4n. The other bits of that word read as zero. Code 0 counts every clock whatever the strobes are. Code c, for 1 ≤ c ≤ NUM_EVT, follows `evt_in[c-1]`. Higher codes never count. The span flag and the pattern word at 0xA00+4n drive `filt_span[n]` and `filt_sid[32n+31:32n]`.
- R5: Writing 1 to bit n of 0xC00 sets count enable n, and writing 1 to bit n of 0xC20 clears it. For interrupt enables the set alias is 0xC40 and the clear alias is 0xC60. Zero bits change nothing. Both aliases read back the current flags.
- R6: A wrap from all ones to zero sets the counter's overflow flag at the same edge. Writing 1s to 0xC80 clears overflow flags, and writing 1s to 0xCC0 sets them. Both addresses read back the flags.
- R7: `irq` is high exactly when the global interrupt enable (bit 0 at 0xE50) is set and at least one counter has both its overflow flag and its interrupt enable set.
- R8: The words 0xE20, 0xE24, 0xE28 and 0xE2C form a 128-bit map of supported event codes. Bits 0 through NUM_EVT are set and all others are clear. With the defaults this gives 0x000000FF, then zeros.
- R9: Addresses of counters at index NCTR or above read as zero and ignore writes. Flag bits at position NCTR or above read as zero.
- R10: A software write to a counter word takes precedence over an increment at the same edge.
- R11: `reg_rdata` loads at the edge where `reg_rd` is sampled high and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 10 | Byte address bits 11:2 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| evt_in | input | NUM_EVT | Event strobes, bit c-1 for code c |
| match_in | input | NCTR | Per-counter stream filter match |
| filt_span | output | NCTR | Per-counter span flag to the filter |
| filt_sid | output | 32*NCTR | Per-counter stream pattern to the filter |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench builds the block with its defaults: eight counters of 48 bits, seven event strobes and a filter per counter. The 48-bit width exercises the two-word layout of each counter and the dropping of high bits written above the width. The map of eight supported codes allows an out-of-range code to be tested next to the highest valid strobe. Eight counters leave the counter addresses and flag bits beyond the implemented range available for the ignored-access checks.

// File: rtl/pctr_pkg.sv
package pctr_pkg;

   localparam logic [11:0] OFS_EVTYPE = 12'h400;
   localparam logic [11:0] OFS_SMR    = 12'hA00;
   localparam logic [11:0] OFS_EN_SET = 12'hC00;
   localparam logic [11:0] OFS_EN_CLR = 12'hC20;
   localparam logic [11:0] OFS_IE_SET = 12'hC40;
   localparam logic [11:0] OFS_IE_CLR = 12'hC60;
   localparam logic [11:0] OFS_OV_CLR = 12'hC80;
   localparam logic [11:0] OFS_OV_SET = 12'hCC0;
   localparam logic [11:0] OFS_CFG    = 12'hE00;
   localparam logic [11:0] OFS_CTRL   = 12'hE04;
   localparam logic [11:0] OFS_CAPS   = 12'hE20;
   localparam logic [11:0] OFS_IRQC   = 12'hE50;

   localparam int SPAN_BIT = 29;

   typedef enum logic [3:0] {
      RG_NONE, RG_CNT, RG_EVT, RG_SMR, RG_EN, RG_IE, RG_OV,
      RG_CFG, RG_CTRL, RG_CAPS, RG_IRQC
   } reg_grp_e;

   typedef struct packed {
      reg_grp_e   grp;
      logic [7:0] idx;
      logic       hi;
      logic       alias_set;
   } reg_sel_t;

endpackage

// File: rtl/pctr_decode.sv
module pctr_decode
   import pctr_pkg::*;
#(
   parameter int CTR_W = 48
) (
   input  logic [11:2] addr,
   output reg_sel_t    sel
);
   localparam bit WIDE = (CTR_W > 32);

   logic [11:0] word;
   logic [11:0] pair;
   logic [11:0] quad;

   assign word = {addr, 2'b00};
   assign pair = {addr[11:3], 3'b000};
   assign quad = {addr[11:4], 4'b0000};

   always_comb begin
      sel.grp       = RG_NONE;
      sel.idx       = '0;
      sel.hi        = 1'b0;
      sel.alias_set = 1'b0;
      if (addr[11:10] == 2'b00) begin
         sel.grp = RG_CNT;
         if (WIDE) begin
            sel.idx = {1'b0, addr[9:3]};
            sel.hi  = addr[2];
         end else begin
            sel.idx = addr[9:2];
         end
      end else if (addr[11:10] == OFS_EVTYPE[11:10]) begin
         sel.grp = RG_EVT;
         sel.idx = addr[9:2];
      end else if (addr[11:8] == OFS_SMR[11:8]) begin
         sel.grp = RG_SMR;
         sel.idx = {2'b00, addr[7:2]};
      end else begin
         sel.hi = addr[2];
         case (pair)
            OFS_EN_SET: begin sel.grp = RG_EN; sel.alias_set = 1'b1; end
            OFS_EN_CLR: sel.grp = RG_EN;
            OFS_IE_SET: begin sel.grp = RG_IE; sel.alias_set = 1'b1; end
            OFS_IE_CLR: sel.grp = RG_IE;
            OFS_OV_SET: begin sel.grp = RG_OV; sel.alias_set = 1'b1; end
            OFS_OV_CLR: sel.grp = RG_OV;
            default: ;
         endcase
         if (quad == OFS_CAPS) begin
            sel.grp = RG_CAPS;
            sel.idx = {6'b0, addr[3:2]};
         end
         if (word == OFS_CFG)  sel.grp = RG_CFG;
         if (word == OFS_CTRL) sel.grp = RG_CTRL;
         if (word == OFS_IRQC) sel.grp = RG_IRQC;
      end
   end
endmodule

// File: rtl/pctr_bitmap.sv
module pctr_bitmap #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_m,
   input  logic [N-1:0] clr_m,
   input  logic [N-1:0] hw_set,
   output logic [N-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= ((q | set_m) & ~clr_m) | hw_set;
   end

   // R6: a hardware set lands at the next edge whatever software writes
   a_r6_hw_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (|hw_set) |=> ((q & $past(hw_set)) == $past(hw_set)));

   // R5: no flag rises without a set request
   a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
      (set_m == '0 && hw_set == '0) |=> ((q & ~$past(q)) == '0));
endmodule

// File: rtl/pctr_slice.sv
module pctr_slice
   import pctr_pkg::*;
#(
   parameter int CTR_W   = 48,
   parameter int NUM_EVT = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_lo,
   input  logic               wr_hi,
   input  logic               wr_evt,
   input  logic               wr_smr,
   input  logic [31:0]        wdata,
   input  logic [NUM_EVT-1:0] evt_in,
   input  logic               cnt_ok,
   output logic [CTR_W-1:0]   value,
   output logic [15:0]        evt_code,
   output logic               span,
   output logic [31:0]        smr,
   output logic               wrap
);
   logic [CTR_W-1:0] wr_val;
   logic             wr_any;
   logic             hit;
   logic             inc;

   assign wr_any = wr_lo | wr_hi;

   generate
      if (CTR_W > 32) begin : g_wide
         always_comb begin
            wr_val = value;
            if (wr_lo) wr_val[31:0]       = wdata;
            if (wr_hi) wr_val[CTR_W-1:32] = wdata[CTR_W-33:0];
         end
         // R10: a low-word write wins over a same-edge increment
         a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_lo && !wr_hi) |=> (value[31:0] == $past(wdata)));
      end else begin : g_narrow
         always_comb begin
            wr_val = value;
            if (wr_any) wr_val = wdata[CTR_W-1:0];
         end
         // R10: a write wins over a same-edge increment
         a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
            wr_lo |=> (value == $past(wdata[CTR_W-1:0])));
      end
   endgenerate

   always_comb begin
      hit = (evt_code == 16'd0);
      for (int e = 1; e <= NUM_EVT; e++) begin
         if (evt_code == 16'(e)) hit = evt_in[e-1];
      end
   end

   assign inc  = cnt_ok & hit;
   assign wrap = inc & ~wr_any & (&value);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      value <= '0;
      else if (wr_any) value <= wr_val;
      else if (inc)    value <= value + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_code <= '0;
         span     <= 1'b0;
      end else if (wr_evt) begin
         evt_code <= wdata[15:0];
         span     <= wdata[SPAN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      smr <= '0;
      else if (wr_smr) smr <= wdata;
   end

   // R3: without a write and without the count qualifiers the value holds
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_any && !cnt_ok) |=> $stable(value));

   // R6: a wrap leaves the counter at zero
   a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (value == '0));
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
   import pctr_pkg::*;
#(
   parameter int NCTR          = 8,
   parameter int CTR_W         = 48,
   parameter int NUM_EVT       = 7,
   parameter bit GLOBAL_FILTER = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [11:2]          reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic [NUM_EVT-1:0]   evt_in,
   input  logic [NCTR-1:0]      match_in,
   output logic [NCTR-1:0]      filt_span,
   output logic [NCTR*32-1:0]   filt_sid,
   output logic                 irq
);
   localparam logic [127:0] CAPS_MAP = (128'd1 << (NUM_EVT + 1)) - 128'd1;
   localparam logic [31:0]  CFG_WORD = {8'h00, GLOBAL_FILTER, 3'b000, 6'b000000,
                                        6'(CTR_W - 1), 2'b00, 6'(NCTR - 1)};

   initial begin
      a_par_nctr: assert (NCTR >= 1 && NCTR <= 64)
         else $error("NCTR out of range");
      a_par_width: assert (CTR_W >= 2 && CTR_W <= 64)
         else $error("CTR_W out of range");
      a_par_events: assert (NUM_EVT >= 1 && NUM_EVT <= 127)
         else $error("NUM_EVT out of range");
   end

   reg_sel_t sel;

   pctr_decode #(.CTR_W(CTR_W)) u_dec (
      .addr (reg_addr),
      .sel  (sel)
   );

   logic             glb_en, irq_en;
   logic [NCTR-1:0]  en_q, ie_q, ov_q;
   logic [NCTR-1:0]  en_set, en_clr, ie_set, ie_clr, ov_set, ov_clr;
   logic [NCTR-1:0]  wrap_v, match_eff, cnt_ok, span_v;
   logic [CTR_W-1:0] cnt_val  [NCTR];
   logic [15:0]      code_val [NCTR];
   logic [31:0]      smr_val  [NCTR];

   generate
      for (genvar n = 0; n < NCTR; n++) begin : g_ctr
         logic wr_lo, wr_hi, wr_evt, wr_smr, mbit;

         assign wr_lo  = reg_wr && sel.grp == RG_CNT && sel.idx == 8'(n) && !sel.hi;
         assign wr_hi  = reg_wr && sel.grp == RG_CNT && sel.idx == 8'(n) &&  sel.hi;
         assign wr_evt = reg_wr && sel.grp == RG_EVT && sel.idx == 8'(n);
         assign wr_smr = reg_wr && sel.grp == RG_SMR && sel.idx == 8'(n);

         assign mbit = reg_wdata[n % 32] && (sel.hi == (n >= 32));
         assign en_set[n] = reg_wr && sel.grp == RG_EN &&  sel.alias_set && mbit;
         assign en_clr[n] = reg_wr && sel.grp == RG_EN && !sel.alias_set && mbit;
         assign ie_set[n] = reg_wr && sel.grp == RG_IE &&  sel.alias_set && mbit;
         assign ie_clr[n] = reg_wr && sel.grp == RG_IE && !sel.alias_set && mbit;
         assign ov_set[n] = reg_wr && sel.grp == RG_OV &&  sel.alias_set && mbit;
         assign ov_clr[n] = reg_wr && sel.grp == RG_OV && !sel.alias_set && mbit;

         if (GLOBAL_FILTER) begin : g_shared
            assign match_eff[n] = match_in[0];
         end else begin : g_own
            assign match_eff[n] = match_in[n];
         end

         assign cnt_ok[n] = glb_en & en_q[n] & match_eff[n];

         pctr_slice #(.CTR_W(CTR_W), .NUM_EVT(NUM_EVT)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (wr_lo),
            .wr_hi    (wr_hi),
            .wr_evt   (wr_evt),
            .wr_smr   (wr_smr),
            .wdata    (reg_wdata),
            .evt_in   (evt_in),
            .cnt_ok   (cnt_ok[n]),
            .value    (cnt_val[n]),
            .evt_code (code_val[n]),
            .span     (span_v[n]),
            .smr      (smr_val[n]),
            .wrap     (wrap_v[n])
         );

         assign filt_span[n]         = span_v[n];
         assign filt_sid[n*32 +: 32] = smr_val[n];
      end
   endgenerate

   pctr_bitmap #(.N(NCTR)) u_en (
      .clk (clk), .rst_n (rst_n), .set_m (en_set), .clr_m (en_clr),
      .hw_set ('0), .q (en_q)
   );

   pctr_bitmap #(.N(NCTR)) u_ie (
      .clk (clk), .rst_n (rst_n), .set_m (ie_set), .clr_m (ie_clr),
      .hw_set ('0), .q (ie_q)
   );

   pctr_bitmap #(.N(NCTR)) u_ov (
      .clk (clk), .rst_n (rst_n), .set_m (ov_set), .clr_m (ov_clr),
      .hw_set (wrap_v), .q (ov_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_en <= 1'b0;
         irq_en <= 1'b0;
      end else if (reg_wr) begin
         if (sel.grp == RG_CTRL) glb_en <= reg_wdata[0];
         if (sel.grp == RG_IRQC) irq_en <= reg_wdata[0];
      end
   end

   assign irq = irq_en & (|(ov_q & ie_q));

   logic [31:0] rd_val;
   logic [63:0] wide_v;

   always_comb begin
      rd_val = '0;
      wide_v = '0;
      case (sel.grp)
         RG_CNT: begin
            for (int n = 0; n < NCTR; n++) begin
               if (sel.idx == 8'(n)) wide_v = 64'(cnt_val[n]);
            end
            rd_val = sel.hi ? wide_v[63:32] : wide_v[31:0];
         end
         RG_EVT: begin
            for (int n = 0; n < NCTR; n++) begin
               if (sel.idx == 8'(n)) rd_val = {2'b00, span_v[n], 13'b0, code_val[n]};
            end
         end
         RG_SMR: begin
            for (int n = 0; n < NCTR; n++) begin
               if (sel.idx == 8'(n)) rd_val = smr_val[n];
            end
         end
         RG_EN, RG_IE, RG_OV: begin
            if (sel.grp == RG_EN)      wide_v = 64'(en_q);
            else if (sel.grp == RG_IE) wide_v = 64'(ie_q);
            else                       wide_v = 64'(ov_q);
            rd_val = sel.hi ? wide_v[63:32] : wide_v[31:0];
         end
         RG_CFG:  rd_val = CFG_WORD;
         RG_CTRL: rd_val = {31'b0, glb_en};
         RG_CAPS: rd_val = CAPS_MAP[sel.idx[1:0]*32 +: 32];
         RG_IRQC: rd_val = {31'b0, irq_en};
         default: rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_val;
   end

   // R11: read data holds between reads
   a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));

   // R7: clearing the global interrupt enable drops the interrupt
   a_r7_irq_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && sel.grp == RG_IRQC && !reg_wdata[0]) |=> !irq);

   // R7: a set overflow with its enable and the global enable raises the interrupt
   a_r7_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && !(reg_wr && (sel.grp == RG_IRQC || sel.grp == RG_OV || sel.grp == RG_IE))
       && |(ov_q & ie_q)) |=> irq);
endmodule

// File: tb/sim_perf_counter_bank.sv
`timescale 1ns/1ps
module sim_perf_counter_bank;
   localparam int NCTR = 8;
   localparam int CTR_W = 48;
   localparam int NUM_EVT = 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic              reg_rd = 1'b0;
   logic [11:2]       reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic [NUM_EVT-1:0] evt_in = '0;
   logic [NCTR-1:0]   match_in = '1;
   logic [NCTR-1:0]   filt_span;
   logic [NCTR*32-1:0] filt_sid;
   logic              irq;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   perf_counter_bank #(.NCTR(NCTR), .CTR_W(CTR_W), .NUM_EVT(NUM_EVT)) u0 (
      .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_rd (reg_rd),
      .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .evt_in (evt_in), .match_in (match_in), .filt_span (filt_span),
      .filt_sid (filt_sid), .irq (irq)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a[11:2]; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a[11:2];
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(req, 64'(d), 64'(exp));
   endtask

   task automatic pulse(input logic [NUM_EVT-1:0] v, input int k);
      @(negedge clk);
      evt_in = v;
      repeat (k) @(negedge clk);
      evt_in = '0;
   endtask

   task automatic t_reset;
      check("R1 rdata", 64'(reg_rdata), 64'h0);
      check("R1 irq", 64'(irq), 64'h0);
      rd_chk("R1 cfg word", 12'hE00, 32'h0000_2F07);
      rd_chk("R1 counter0", 12'h000, 32'h0);
      rd_chk("R1 enables", 12'hC00, 32'h0);
   endtask

   task automatic t_caps;
      rd_chk("R8 caps w0", 12'hE20, 32'h0000_00FF);
      rd_chk("R8 caps w1", 12'hE24, 32'h0);
      rd_chk("R8 caps w2", 12'hE28, 32'h0);
      rd_chk("R8 caps w3", 12'hE2C, 32'h0);
   endtask

   task automatic t_layout;
      wr(12'h028, 32'h1234_5678);
      wr(12'h02C, 32'hABCD_1234);
      rd_chk("R2 ctr5 low", 12'h028, 32'h1234_5678);
      rd_chk("R2 ctr5 high masked", 12'h02C, 32'h0000_1234);
   endtask

   task automatic t_unimpl;
      wr(12'h040, 32'hDEAD_BEEF);
      rd_chk("R9 ctr8 ignored", 12'h040, 32'h0);
      wr(12'hC00, 32'hFFFF_FFFF);
      rd_chk("R9 enable upper bits", 12'hC00, 32'h0000_00FF);
      rd_chk("R9 enable high word", 12'hC04, 32'h0);
      rd_chk("R5 clear alias reads", 12'hC20, 32'h0000_00FF);
      wr(12'hC20, 32'hFFFF_FFFF);
      rd_chk("R5 clear all", 12'hC00, 32'h0);
   endtask

   task automatic t_alias;
      wr(12'hC00, 32'h05);
      rd_chk("R5 set 05", 12'hC00, 32'h05);
      wr(12'hC00, 32'h02);
      rd_chk("R5 set adds", 12'hC00, 32'h07);
      wr(12'hC20, 32'h04);
      rd_chk("R5 clear one", 12'hC20, 32'h03);
      wr(12'hC40, 32'h09);
      rd_chk("R5 ie set", 12'hC60, 32'h09);
      wr(12'hC20, 32'hFF);
      wr(12'hC60, 32'hFF);
      rd_chk("R5 ie cleared", 12'hC40, 32'h0);
   endtask

   task automatic t_count;
      wr(12'h408, 32'h3);
      wr(12'hC00, 32'h04);
      wr(12'hE04, 32'h1);
      pulse(7'b0000100, 5);
      rd_chk("R3 five events", 12'h010, 32'd5);
      match_in[2] = 1'b0;
      pulse(7'b0000100, 4);
      rd_chk("R3 no match holds", 12'h010, 32'd5);
      match_in[2] = 1'b1;
      pulse(7'b1111011, 3);
      rd_chk("R3 other strobes", 12'h010, 32'd5);
      wr(12'hC20, 32'h04);
      pulse(7'b0000100, 3);
      rd_chk("R3 disabled holds", 12'h010, 32'd5);
      wr(12'hC00, 32'h04);
      wr(12'hE04, 32'h0);
      pulse(7'b0000100, 3);
      rd_chk("R3 global off holds", 12'h010, 32'd5);
      pulse(7'b0000100, 2);
      wr(12'hC20, 32'hFF);
   endtask

   task automatic t_codes;
      wr(12'h40C, 32'hFFFF_FFFF);
      rd_chk("R4 selector fields", 12'h40C, 32'h2000_FFFF);
      check("R4 span out", 64'(filt_span[3]), 64'h1);
      wr(12'h40C, 32'h0);
      check("R4 span cleared", 64'(filt_span[3]), 64'h0);
      wr(12'hA0C, 32'h42);
      check("R4 pattern out", 64'(filt_sid[3*32 +: 32]), 64'h42);
      rd_chk("R4 pattern read", 12'hA0C, 32'h42);
      wr(12'hC00, 32'h08);
      wr(12'hE04, 32'h1);
      wr(12'hE04, 32'h0);
      rd_chk("R4 code0 counts cycles", 12'h018, 32'd2);
      wr(12'hC20, 32'h08);
      wr(12'h410, 32'h8);
      wr(12'h414, 32'h7);
      wr(12'h028, 32'h0);
      wr(12'h02C, 32'h0);
      wr(12'hC00, 32'h30);
      wr(12'hE04, 32'h1);
      pulse('1, 4);
      wr(12'hE04, 32'h0);
      rd_chk("R4 code above range", 12'h020, 32'd0);
      rd_chk("R4 highest code", 12'h028, 32'd4);
      wr(12'hC20, 32'hFF);
   endtask

   task automatic t_precedence;
      wr(12'h400 + 12'h4, 32'h0);
      wr(12'hC00, 32'h02);
      wr(12'hE04, 32'h1);
      wr(12'h008, 32'd100);
      wr(12'hE04, 32'h0);
      rd_chk("R10 write wins", 12'h008, 32'd102);
      rd_chk("R10 high word", 12'h00C, 32'd0);
      wr(12'hC20, 32'hFF);
   endtask

   task automatic t_wrap;
      wr(12'h400, 32'h1);
      wr(12'h000, 32'hFFFF_FFFF);
      wr(12'h004, 32'hFFFF_FFFF);
      rd_chk("R2 high bits dropped", 12'h004, 32'h0000_FFFF);
      wr(12'hC00, 32'h01);
      wr(12'hC40, 32'h01);
      wr(12'hE50, 32'h1);
      wr(12'hE04, 32'h1);
      check("R7 no overflow no irq", 64'(irq), 64'h0);
      rd_chk("R6 flag clear before", 12'hCC0, 32'h0);
      pulse(7'b0000001, 1);
      check("R7 irq on wrap", 64'(irq), 64'h1);
      rd_chk("R6 wrapped low", 12'h000, 32'h0);
      rd_chk("R6 wrapped high", 12'h004, 32'h0);
      rd_chk("R6 flag set", 12'hCC0, 32'h1);
      rd_chk("R6 flag on clear alias", 12'hC80, 32'h1);
      wr(12'hC80, 32'h1);
      check("R7 irq after clear", 64'(irq), 64'h0);
      rd_chk("R6 flag cleared", 12'hCC0, 32'h0);
      wr(12'hCC0, 32'h1);
      check("R7 irq after sw set", 64'(irq), 64'h1);
      wr(12'hE50, 32'h0);
      check("R7 global gate", 64'(irq), 64'h0);
      wr(12'hE50, 32'h1);
      check("R7 gate restored", 64'(irq), 64'h1);
      wr(12'hC60, 32'h1);
      check("R7 ie cleared", 64'(irq), 64'h0);
      wr(12'hE04, 32'h0);
   endtask

   task automatic t_hold;
      logic [31:0] d;
      rd(12'hE00, d);
      @(negedge clk);
      reg_addr = '0;
      repeat (3) @(negedge clk);
      check("R11 rdata holds", 64'(reg_rdata), 64'h0000_2F07);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_caps;
      t_layout;
      t_unimpl;
      t_alias;
      t_count;
      t_codes;
      t_precedence;
      t_wrap;
      t_hold;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #400000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule